// File: doc/BRIEF.md
# Nibble-Multiplexed Transmit Input Port

This block sits at the head of a transmit data path. Each port clock brings one half-word on a narrow bus, together with a sync strobe. The block joins consecutive half-words into full sample words. Each finished word goes out with a one-cycle valid strobe to the interpolation stage that follows. The sync strobe is high on the first half-word of a pair and low on the second.

Four static configuration inputs set how the port works:
- which clock edge captures the bus,
- which half-word lands in the upper bits,
- whether half-words are full width (6+6) or narrow (5+5),
- whether the sign bit of outgoing data is inverted, which gives offset-binary output.

A gain-select input sends finished words to a gain register write port instead of the data output. A wrapping counter tracks framing errors, where two first half-words arrive back to back.

Top module: `txnib_port`

## Requirements
- R1: A synchronous active-high `rst` clears `word_vld`, `gain_wr`, `word_out`, `gain_q`, `err_cnt` and any pending half-word.
- R2: A half-word captured with `sync_in` high opens a pair, and the next half-word captured with `sync_in` low closes it. In the default order the opening half-word forms bits [11:6] and the closing one bits [5:0], in two's complement. `word_vld` pulses for one cycle. The word is visible after the clock edge that follows the edge capturing the closing half-word.
- R3: With `cfg_swap` high, the closing half-word forms the upper bits and the opening one the lower bits.
- R4: With `cfg_narrow` high, only bits [4:0] of each half-word are used. The result is placed as {upper[4:0], lower[4:0], 2'b00}, so bits [1:0] of the word are zero.
- R5: With `cfg_offset_bin` high, bit 11 of `word_out` is inverted and all other bits are unchanged.
- R6: With `cfg_fall_edge` low, the bus is sampled at the rising clock edge. With it high, the bus is sampled at the preceding falling edge, and changes between that falling edge and the next rising edge are ignored. Output latency is the same in both modes.
- R7: When `sync_in` is high on two consecutive half-words, the older pending half-word is dropped, pairing restarts from the newer one, and `err_cnt` rises by one. `err_cnt` wraps at its width.
- R8: A half-word with `sync_in` low and no pair open is dropped and produces no output.
- R9: When `gain_sel` is high at the cycle a pair completes, the word, with no sign inversion, is loaded into `gain_q` and `gain_wr` pulses instead of `word_vld`. `gain_q` holds its value at all other times.
- R10: `word_vld` and `gain_wr` are never high together, and neither is high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_fall_edge | input | 1 | Capture the bus on the falling edge |
| cfg_swap | input | 1 | Place the closing half-word in the upper bits |
| cfg_narrow | input | 1 | Use the 5+5 split |
| cfg_offset_bin | input | 1 | Invert the sign bit of data output |
| gain_sel | input | 1 | Route words to the gain register |
| half_in | input | HALF_W (6) | Half-word data bus |
| sync_in | input | 1 | High on the opening half-word |
| word_out | output | 2*HALF_W (12) | Assembled sample word |
| word_vld | output | 1 | One-cycle strobe for `word_out` |
| gain_wr | output | 1 | One-cycle gain register write strobe |
| gain_q | output | 2*HALF_W (12) | Gain register contents |
| err_cnt | output | ERR_W (8) | Count of framing errors |

## Verification
A half-word driven just after rising edge P is captured at edge P+1. Outputs that depend on it, including the word, the gain write and the error count increment, appear after edge P+2. The bench keeps a two-deep queue of expected values from its own model. It compares each queue entry two drive steps later, one time unit after a rising edge.

In falling-edge mode the bench overwrites the bus with junk between the falling edge and the next rising edge, so a wrong capture edge shows up in the word. Configuration changes only after three idle steps, which lets every pending word leave the pipeline first.

// File: rtl/txnib_pkg.sv
package txnib_pkg;
   // pairing state: either no half-word waiting, or one opening half-word held
   typedef enum logic {
      PS_EMPTY = 1'b0,
      PS_HOLD  = 1'b1
   } pair_st_e;
endpackage

// File: rtl/txnib_capture.sv
module txnib_capture #(
   parameter int HALF_W      = 6,
   parameter bit FALL_CAP_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              fall_sel,
   input  logic [HALF_W-1:0] half_in,
   input  logic              sync_in,
   output logic [HALF_W-1:0] cap_half,
   output logic              cap_sync
);
   localparam int BUS_W = HALF_W + 1;

   logic [BUS_W-1:0] bus_now;
   logic [BUS_W-1:0] bus_sel;

   assign bus_now = {sync_in, half_in};

   generate
      if (FALL_CAP_EN) begin : g_fall
         logic [BUS_W-1:0] neg_q;
         // half-cycle early sample, re-timed at the next rising edge
         always_ff @(negedge clk) begin
            if (rst) neg_q <= '0;
            else     neg_q <= bus_now;
         end
         assign bus_sel = fall_sel ? neg_q : bus_now;
      end else begin : g_rise
         assign bus_sel = bus_now;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) {cap_sync, cap_half} <= '0;
      else     {cap_sync, cap_half} <= bus_sel;
   end
endmodule

// File: rtl/txnib_pair.sv
module txnib_pair
   import txnib_pkg::*;
#(
   parameter int HALF_W = 6,
   parameter int ERR_W  = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [HALF_W-1:0] cap_half,
   input  logic              cap_sync,
   output logic              pair_vld,
   output logic [HALF_W-1:0] pair_first,
   output logic [HALF_W-1:0] pair_second,
   output logic [ERR_W-1:0]  err_cnt
);
   pair_st_e          st_q;
   logic [HALF_W-1:0] first_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q    <= PS_EMPTY;
         first_q <= '0;
         err_cnt <= '0;
      end else if (cap_sync) begin
         // a new opening half-word always wins; a stale one is an error (R7)
         if (st_q == PS_HOLD) err_cnt <= err_cnt + 1'b1;
         first_q <= cap_half;
         st_q    <= PS_HOLD;
      end else begin
         // closing half-word completes a pair, or a stray is dropped (R8)
         st_q <= PS_EMPTY;
      end
   end

   assign pair_vld    = (st_q == PS_HOLD) && !cap_sync;
   assign pair_first  = first_q;
   assign pair_second = cap_half;
endmodule

// File: rtl/txnib_pack.sv
module txnib_pack #(
   parameter int HALF_W   = 6,
   parameter int NARROW_W = 5
) (
   input  logic [HALF_W-1:0]   first_h,
   input  logic [HALF_W-1:0]   second_h,
   input  logic                swap,
   input  logic                narrow,
   output logic [2*HALF_W-1:0] word
);
   localparam int WORD_W = 2 * HALF_W;
   localparam int PAD_W  = 2 * (HALF_W - NARROW_W);

   logic [HALF_W-1:0] hi_h;
   logic [HALF_W-1:0] lo_h;
   logic [WORD_W-1:0] wide_w;
   logic [WORD_W-1:0] slim_w;

   assign hi_h   = swap ? second_h : first_h;
   assign lo_h   = swap ? first_h  : second_h;
   assign wide_w = {hi_h, lo_h};

   generate
      if (PAD_W > 0) begin : g_pad
         // left-justify the short sample so the sign stays at the top bit
         assign slim_w = {hi_h[NARROW_W-1:0], lo_h[NARROW_W-1:0], {PAD_W{1'b0}}};
      end else begin : g_nopad
         assign slim_w = wide_w;
      end
   endgenerate

   assign word = narrow ? slim_w : wide_w;
endmodule

// File: rtl/txnib_port.sv
module txnib_port #(
   parameter int HALF_W      = 6,
   parameter int NARROW_W    = 5,
   parameter int ERR_W       = 8,
   parameter bit FALL_CAP_EN = 1'b1
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                cfg_fall_edge,
   input  logic                cfg_swap,
   input  logic                cfg_narrow,
   input  logic                cfg_offset_bin,
   input  logic                gain_sel,
   input  logic [HALF_W-1:0]   half_in,
   input  logic                sync_in,
   output logic [2*HALF_W-1:0] word_out,
   output logic                word_vld,
   output logic                gain_wr,
   output logic [2*HALF_W-1:0] gain_q,
   output logic [ERR_W-1:0]    err_cnt
);
   localparam int WORD_W = 2 * HALF_W;

   generate
      if (HALF_W < 2) begin : g_bad_half
         $error("txnib_port: HALF_W must be at least 2");
      end
      if (NARROW_W < 1 || NARROW_W > HALF_W) begin : g_bad_narrow
         $error("txnib_port: NARROW_W must lie in 1..HALF_W");
      end
      if (ERR_W < 1) begin : g_bad_err
         $error("txnib_port: ERR_W must be at least 1");
      end
   endgenerate

   logic [HALF_W-1:0] cap_half;
   logic              cap_sync;
   logic              pair_vld;
   logic [HALF_W-1:0] pair_first;
   logic [HALF_W-1:0] pair_second;
   logic [WORD_W-1:0] packed_w;
   logic [WORD_W-1:0] sign_flip;

   txnib_capture #(.HALF_W(HALF_W), .FALL_CAP_EN(FALL_CAP_EN)) u_cap (
      .clk      (clk),
      .rst      (rst),
      .fall_sel (cfg_fall_edge),
      .half_in  (half_in),
      .sync_in  (sync_in),
      .cap_half (cap_half),
      .cap_sync (cap_sync)
   );

   txnib_pair #(.HALF_W(HALF_W), .ERR_W(ERR_W)) u_pair (
      .clk         (clk),
      .rst         (rst),
      .cap_half    (cap_half),
      .cap_sync    (cap_sync),
      .pair_vld    (pair_vld),
      .pair_first  (pair_first),
      .pair_second (pair_second),
      .err_cnt     (err_cnt)
   );

   txnib_pack #(.HALF_W(HALF_W), .NARROW_W(NARROW_W)) u_pack (
      .first_h  (pair_first),
      .second_h (pair_second),
      .swap     (cfg_swap),
      .narrow   (cfg_narrow),
      .word     (packed_w)
   );

   assign sign_flip = {cfg_offset_bin, {(WORD_W-1){1'b0}}};

   always_ff @(posedge clk) begin
      if (rst) begin
         word_out <= '0;
         word_vld <= 1'b0;
         gain_wr  <= 1'b0;
         gain_q   <= '0;
      end else begin
         word_vld <= pair_vld && !gain_sel;
         gain_wr  <= pair_vld && gain_sel;
         if (pair_vld && !gain_sel) word_out <= packed_w ^ sign_flip;
         if (pair_vld && gain_sel)  gain_q   <= packed_w;
      end
   end
endmodule

// File: rtl/txnib_port_chk.sv
module txnib_port_chk #(
   parameter int HALF_W   = 6,
   parameter int NARROW_W = 5,
   parameter int ERR_W    = 8
) (
   input logic                clk,
   input logic                rst,
   input logic                cfg_narrow,
   input logic                gain_sel,
   input logic [2*HALF_W-1:0] word_out,
   input logic                word_vld,
   input logic                gain_wr,
   input logic [2*HALF_W-1:0] gain_q,
   input logic [ERR_W-1:0]    err_cnt
);
   localparam int PAD_W = 2 * (HALF_W - NARROW_W);

   p_excl_r10: assert property (@(posedge clk) disable iff (rst)
      !(word_vld && gain_wr));

   p_spacing_r10: assert property (@(posedge clk) disable iff (rst)
      (word_vld || gain_wr) |=> !(word_vld || gain_wr));

   p_err_step_r7: assert property (@(posedge clk) disable iff (rst)
      (err_cnt != $past(err_cnt)) |-> (err_cnt == ERR_W'($past(err_cnt) + 1'b1)));

   p_gain_hold_r9: assert property (@(posedge clk) disable iff (rst)
      !gain_wr |-> $stable(gain_q));

   p_gain_route_r9: assert property (@(posedge clk) disable iff (rst)
      gain_wr |-> $past(gain_sel));

   p_data_route_r9: assert property (@(posedge clk) disable iff (rst)
      word_vld |-> !$past(gain_sel));

   generate
      if (PAD_W > 0) begin : g_pad_chk
         p_pad_zero_r4: assert property (@(posedge clk) disable iff (rst)
            (word_vld && $past(cfg_narrow)) |-> (word_out[PAD_W-1:0] == '0));
      end
   endgenerate
endmodule

bind txnib_port txnib_port_chk #(
   .HALF_W   (HALF_W),
   .NARROW_W (NARROW_W),
   .ERR_W    (ERR_W)
) u_chk (.*);

// File: tb/txnib_port_bench.sv
module txnib_port_bench;
   localparam int HW = 6;
   localparam int NW = 5;
   localparam int EW = 8;
   localparam int WW = 2 * HW;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          cfg_fall_edge = 1'b0;
   logic          cfg_swap = 1'b0;
   logic          cfg_narrow = 1'b0;
   logic          cfg_offset_bin = 1'b0;
   logic          gain_sel = 1'b0;
   logic [HW-1:0] half_in = '0;
   logic          sync_in = 1'b0;
   logic [WW-1:0] word_out;
   logic          word_vld;
   logic          gain_wr;
   logic [WW-1:0] gain_q;
   logic [EW-1:0] err_cnt;

   always #2 clk = ~clk; // 250 MHz

   txnib_port u_txnib_port (
      .clk(clk), .rst(rst), .cfg_fall_edge(cfg_fall_edge), .cfg_swap(cfg_swap),
      .cfg_narrow(cfg_narrow), .cfg_offset_bin(cfg_offset_bin), .gain_sel(gain_sel),
      .half_in(half_in), .sync_in(sync_in), .word_out(word_out), .word_vld(word_vld),
      .gain_wr(gain_wr), .gain_q(gain_q), .err_cnt(err_cnt)
   );

   int    n_chk = 0;
   int    n_err = 0;
   bit    done  = 1'b0;
   string tag   = "R1";

   // bench model state
   bit            m_has = 1'b0;
   logic [HW-1:0] m_first = '0;
   logic [EW-1:0] m_err = '0;
   logic [WW-1:0] m_gq = '0;
   // expected outputs, queue depth two
   logic          e0_vld = 0, e1_vld = 0, e0_gwr = 0, e1_gwr = 0;
   logic [WW-1:0] e0_word = '0, e1_word = '0, e0_gq = '0, e1_gq = '0;
   logic [EW-1:0] e0_err = '0, e1_err = '0;

   task automatic check(input bit ok, input string what, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   function automatic logic [WW-1:0] build(input logic [HW-1:0] a, input logic [HW-1:0] b,
                                           input bit sw, input bit nar);
      logic [HW-1:0] hi = sw ? b : a;
      logic [HW-1:0] lo = sw ? a : b;
      if (nar) return {hi[NW-1:0], lo[NW-1:0], {(WW-2*NW){1'b0}}};
      return {hi, lo};
   endfunction

   task automatic step(input logic [HW-1:0] d, input bit s);
      logic          n_vld, n_gwr;
      logic [WW-1:0] n_word;
      // compare what the design shows now against the entry from two steps back
      check(word_vld === e1_vld, "word_vld", word_vld, e1_vld);
      if (e1_vld) check(word_out === e1_word, "word_out", word_out, e1_word);
      check(gain_wr === e1_gwr, "gain_wr", gain_wr, e1_gwr);
      check(gain_q === e1_gq, "gain_q", gain_q, e1_gq);
      check(err_cnt === e1_err, "err_cnt", err_cnt, e1_err);
      e1_vld = e0_vld; e1_gwr = e0_gwr; e1_word = e0_word; e1_gq = e0_gq; e1_err = e0_err;
      // model
      n_vld = 0; n_gwr = 0; n_word = e0_word;
      if (s) begin
         if (m_has) m_err = m_err + 1'b1;
         m_has = 1; m_first = d;
      end else if (m_has) begin
         m_has = 0;
         if (gain_sel) begin
            n_gwr = 1; m_gq = build(m_first, d, cfg_swap, cfg_narrow);
         end else begin
            n_vld = 1;
            n_word = build(m_first, d, cfg_swap, cfg_narrow);
            if (cfg_offset_bin) n_word[WW-1] = ~n_word[WW-1];
         end
      end
      e0_vld = n_vld; e0_gwr = n_gwr; e0_word = n_word; e0_gq = m_gq; e0_err = m_err;
      half_in = d; sync_in = s;
      if (cfg_fall_edge) begin
         #2; // past the falling edge: junk must not be captured
         half_in = ~d; sync_in = ~s;
      end
      @(posedge clk); #1;
   endtask

   task automatic pair(input logic [HW-1:0] a, input logic [HW-1:0] b);
      step(a, 1); step(b, 0);
   endtask

   task automatic flush();
      for (int i = 0; i < 3; i++) step(HW'($urandom), 0);
   endtask

   task automatic rand_units(input int n);
      bit pend = 0;
      for (int i = 0; i < n; i++) begin
         int r = $urandom % 8;
         if (r == 0 && i < n - 1) begin
            step(HW'($urandom), 1); pend = 1;          // lone opener
         end else if (r == 1 && !pend && i < n - 1) begin
            step(HW'($urandom), 0);                    // stray closer
         end else begin
            pair(HW'($urandom), HW'($urandom)); pend = 0;
         end
      end
   endtask

   initial begin
      void'($urandom(32'h5EED_0042));
      repeat (4) @(posedge clk);
      #1;
      // R1: reset state
      tag = "R1";
      check(word_vld === 0, "word_vld", word_vld, 0);
      check(gain_wr === 0, "gain_wr", gain_wr, 0);
      check(word_out === 0, "word_out", word_out, 0);
      check(gain_q === 0, "gain_q", gain_q, 0);
      check(err_cnt === 0, "err_cnt", err_cnt, 0);
      rst = 1'b0;

      tag = "R2"; // default order, two's complement extremes
      pair(6'h1F, 6'h3F); pair(6'h20, 6'h00); pair(6'h3F, 6'h3F);
      pair(6'h00, 6'h01); pair(6'h00, 6'h00);
      rand_units(20); flush();

      tag = "R3"; cfg_swap = 1;
      pair(6'h2A, 6'h15); rand_units(15); flush(); cfg_swap = 0;

      tag = "R4"; cfg_narrow = 1;
      pair(6'h3F, 6'h20); pair(6'h2F, 6'h30); rand_units(15); flush();
      cfg_swap = 1; pair(6'h21, 6'h1E); flush(); cfg_swap = 0; cfg_narrow = 0;

      tag = "R5"; cfg_offset_bin = 1;
      pair(6'h00, 6'h00); pair(6'h20, 6'h00); pair(6'h1F, 6'h3F);
      rand_units(10); flush(); cfg_offset_bin = 0;

      tag = "R6"; cfg_fall_edge = 1;
      pair(6'h12, 6'h34); rand_units(15); flush(); cfg_fall_edge = 0;

      tag = "R7";
      step(6'h11, 1); step(6'h22, 1); step(6'h33, 0);
      step(6'h01, 1); step(6'h02, 1); step(6'h03, 1); step(6'h04, 0);
      rand_units(25); flush();

      tag = "R8";
      step(6'h3C, 0); step(6'h0F, 0); pair(6'h05, 6'h0A); step(6'h3F, 0);
      flush();

      tag = "R9"; gain_sel = 1; cfg_offset_bin = 1;
      pair(6'h2B, 6'h1C); rand_units(10); flush();
      gain_sel = 0; pair(6'h01, 6'h02); flush(); cfg_offset_bin = 0;

      tag = "R10";
      for (int k = 0; k < 8; k++) begin
         cfg_swap = $urandom; cfg_narrow = $urandom; cfg_offset_bin = $urandom;
         cfg_fall_edge = $urandom; gain_sel = $urandom;
         rand_units(12); flush();
      end
      // R7: wrap of the error counter across its full range
      tag = "R7";
      cfg_fall_edge = 0; gain_sel = 0;
      for (int k = 0; k < 300; k++) step(HW'($urandom), 1);
      step(6'h00, 0); flush();

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      #(4 * 200000);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end
endmodule